// File: doc/BRIEF.md
# Field Line-Count Frame-Mode Qualifier

This block watches one video channel and counts how many horizontal lines arrive between two consecutive field-start strobes. When a field-start strobe arrives, the finished count is captured and compared against two acceptance windows, one for 50 Hz sources and one for 60 Hz sources. The result of that comparison tells the display logic which standard the channel carries. It also tells the display logic whether the field is regular enough for interlaced frame display.

A single control input chooses between a tight and a loose pair of windows. Tight windows suit clean broadcast sources. Loose windows tolerate consumer sources with irregular line counts. Both strobes are single-cycle pulses produced by sync separation upstream. A chip uses one instance for the main picture and a second one for the inset, and each instance has its own tolerance input.

Top module: `field_line_qualifier`

## Requirements
- R1: With `relaxed_tol`=0, a completed field of 310 to 315 lines inclusive gives `std_o`=2'b01 (50 Hz) and `frame_ok`=1.
- R2: With `relaxed_tol`=1, a completed field of 290 to 325 lines inclusive gives `std_o`=2'b01 and `frame_ok`=1.
- R3: With `relaxed_tol`=0, a completed field of 260 to 265 lines inclusive gives `std_o`=2'b10 (60 Hz) and `frame_ok`=1.
- R4: With `relaxed_tol`=1, a completed field of 250 to 275 lines inclusive gives `std_o`=2'b10 and `frame_ok`=1.
- R5: A completed count that lies outside both windows selected by `relaxed_tol` gives `std_o`=2'b00 (unknown) and `frame_ok`=0. `relaxed_tol` is used only in the cycle of the field-start strobe.
- R6: The running line count saturates at 1023, so `line_cnt_o` reports min(lines, 1023) and never wraps.
- R7: `line_cnt_o` reports the number of line strobes since the previous field strobe. A line strobe in the same cycle as a field strobe belongs to the new field.
- R8: `upd_valid` is high for exactly the one cycle after each clock edge that samples `field_stb`. At all other times `std_o`, `frame_ok` and `line_cnt_o` keep their values.
- R9: After reset, `std_o`=2'b00, `frame_ok`=0, `line_cnt_o`=0 and `upd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_stb | input | 1 | One-cycle pulse at each line start |
| field_stb | input | 1 | One-cycle pulse at each field start |
| relaxed_tol | input | 1 | 0 selects the tight windows, 1 selects the loose windows |
| std_o | output | 2 | Detected standard: 00 unknown, 01 50 Hz, 10 60 Hz |
| frame_ok | output | 1 | Frame display permitted for the last field |
| line_cnt_o | output | 10 | Line count of the last completed field |
| upd_valid | output | 1 | One-cycle pulse when the outputs update |

## Verification
A line strobe and a field strobe can fall in the same cycle, and the block must then close the old field and count that line for the new field. The bench provokes this by raising both strobes together at the end of one field. It then sends one line fewer in the next field. That field's reported count must equal the full intended number, and the closing field's count must not include the shared line.

// File: rtl/fldq_pkg.sv
package fldq_pkg;
   typedef enum logic [1:0] {
      STD_UNKNOWN = 2'b00,
      STD_50HZ    = 2'b01,
      STD_60HZ    = 2'b10
   } vid_std_e;

   localparam int NUM_STD = 2;
endpackage

// File: rtl/fldq_line_ctr.sv
module fldq_line_ctr #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_stb,
   input  logic             field_stb,
   output logic [CNT_W-1:0] run_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (field_stb) begin
         // a line start coinciding with the field start opens the new field
         run_cnt <= line_stb ? CNT_ONE : '0;
      end else if (line_stb && (run_cnt != CNT_MAX)) begin
         run_cnt <= run_cnt + CNT_ONE;
      end
   end
endmodule

// File: rtl/fldq_win.sv
module fldq_win #(
   parameter int CNT_W  = 10,
   parameter int TGT_LO = 310,
   parameter int TGT_HI = 315,
   parameter int LSE_LO = 290,
   parameter int LSE_HI = 325
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             relaxed,
   output logic             hit
);
   logic [31:0] c32;
   logic        in_tight;
   logic        in_loose;

   always_comb begin
      c32      = 32'(cnt);
      in_tight = (c32 >= 32'(TGT_LO)) && (c32 <= 32'(TGT_HI));
      in_loose = (c32 >= 32'(LSE_LO)) && (c32 <= 32'(LSE_HI));
      hit      = relaxed ? in_loose : in_tight;
   end
endmodule

// File: rtl/field_line_qualifier.sv
module field_line_qualifier
   import fldq_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int S50_LO = 310,
   parameter int S50_HI = 315,
   parameter int R50_LO = 290,
   parameter int R50_HI = 325,
   parameter int S60_LO = 260,
   parameter int S60_HI = 265,
   parameter int R60_LO = 250,
   parameter int R60_HI = 275
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_stb,
   input  logic             field_stb,
   input  logic             relaxed_tol,
   output logic [1:0]       std_o,
   output logic             frame_ok,
   output logic [CNT_W-1:0] line_cnt_o,
   output logic             upd_valid
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   // elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("CNT_W out of supported range");
   end
   if (S50_LO > S50_HI || R50_LO > R50_HI || S60_LO > S60_HI || R60_LO > R60_HI) begin : g_bad_order
      $error("window lower bound above upper bound");
   end
   if (S50_LO < R50_LO || S50_HI > R50_HI || S60_LO < R60_LO || S60_HI > R60_HI) begin : g_bad_nest
      $error("tight window must lie inside loose window");
   end
   if (R50_HI > CNT_MAX || R60_HI > CNT_MAX) begin : g_bad_range
      $error("window exceeds counter range");
   end
   if (!(R60_HI < R50_LO || R50_HI < R60_LO)) begin : g_bad_overlap
      $error("50 Hz and 60 Hz windows overlap");
   end

   logic [CNT_W-1:0]   run_cnt;
   logic [NUM_STD-1:0] hit;
   vid_std_e           std_nxt;

   fldq_line_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_stb  (line_stb),
      .field_stb (field_stb),
      .run_cnt   (run_cnt)
   );

   // one window checker per standard; index 0 = 50 Hz, 1 = 60 Hz
   for (genvar g = 0; g < NUM_STD; g++) begin : g_win
      localparam int TLO = (g == 0) ? S50_LO : S60_LO;
      localparam int THI = (g == 0) ? S50_HI : S60_HI;
      localparam int LLO = (g == 0) ? R50_LO : R60_LO;
      localparam int LHI = (g == 0) ? R50_HI : R60_HI;
      fldq_win #(
         .CNT_W  (CNT_W),
         .TGT_LO (TLO),
         .TGT_HI (THI),
         .LSE_LO (LLO),
         .LSE_HI (LHI)
      ) u_win (
         .cnt     (run_cnt),
         .relaxed (relaxed_tol),
         .hit     (hit[g])
      );
   end

   always_comb begin
      if (hit[0])      std_nxt = STD_50HZ;
      else if (hit[1]) std_nxt = STD_60HZ;
      else             std_nxt = STD_UNKNOWN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         std_o      <= STD_UNKNOWN;
         frame_ok   <= 1'b0;
         line_cnt_o <= '0;
         upd_valid  <= 1'b0;
      end else begin
         upd_valid <= field_stb;
         if (field_stb) begin
            std_o      <= std_nxt;
            frame_ok   <= |hit;
            line_cnt_o <= run_cnt;
         end
      end
   end
endmodule

// File: rtl/field_line_qualifier_chk.sv
module field_line_qualifier_chk #(
   parameter int CNT_W  = 10,
   parameter int S50_LO = 310,
   parameter int S50_HI = 315,
   parameter int R50_LO = 290,
   parameter int R50_HI = 325,
   parameter int S60_LO = 260,
   parameter int S60_HI = 265,
   parameter int R60_LO = 250,
   parameter int R60_HI = 275
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_stb,
   input logic             field_stb,
   input logic             relaxed_tol,
   input logic [CNT_W-1:0] run_cnt,
   input logic [1:0]       std_o,
   input logic             frame_ok,
   input logic [CNT_W-1:0] line_cnt_o,
   input logic             upd_valid
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [31:0] c;
   assign c = 32'(run_cnt);

   a_r1_tight_50: assert property (@(posedge clk) disable iff (!rst_n)
      field_stb && !relaxed_tol && c >= 32'(S50_LO) && c <= 32'(S50_HI)
      |=> std_o == 2'b01 && frame_ok);

   a_r2_loose_50: assert property (@(posedge clk) disable iff (!rst_n)
      field_stb && relaxed_tol && c >= 32'(R50_LO) && c <= 32'(R50_HI)
      |=> std_o == 2'b01 && frame_ok);

   a_r3_tight_60: assert property (@(posedge clk) disable iff (!rst_n)
      field_stb && !relaxed_tol && c >= 32'(S60_LO) && c <= 32'(S60_HI)
      |=> std_o == 2'b10 && frame_ok);

   a_r4_loose_60: assert property (@(posedge clk) disable iff (!rst_n)
      field_stb && relaxed_tol && c >= 32'(R60_LO) && c <= 32'(R60_HI)
      |=> std_o == 2'b10 && frame_ok);

   a_r5_unknown: assert property (@(posedge clk) disable iff (!rst_n)
      field_stb && (relaxed_tol
         ? !((c >= 32'(R50_LO) && c <= 32'(R50_HI)) || (c >= 32'(R60_LO) && c <= 32'(R60_HI)))
         : !((c >= 32'(S50_LO) && c <= 32'(S50_HI)) || (c >= 32'(S60_LO) && c <= 32'(S60_HI))))
      |=> std_o == 2'b00 && !frame_ok);

   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt == CMAX && line_stb && !field_stb |=> run_cnt == CMAX);

   a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      field_stb |=> line_cnt_o == $past(run_cnt));

   a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      field_stb |=> upd_valid);

   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !field_stb |=> !upd_valid);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !field_stb |=> $stable(std_o) && $stable(frame_ok) && $stable(line_cnt_o));
endmodule

bind field_line_qualifier field_line_qualifier_chk #(
   .CNT_W  (CNT_W),
   .S50_LO (S50_LO), .S50_HI (S50_HI), .R50_LO (R50_LO), .R50_HI (R50_HI),
   .S60_LO (S60_LO), .S60_HI (S60_HI), .R60_LO (R60_LO), .R60_HI (R60_HI)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_stb    (line_stb),
   .field_stb   (field_stb),
   .relaxed_tol (relaxed_tol),
   .run_cnt     (run_cnt),
   .std_o       (std_o),
   .frame_ok    (frame_ok),
   .line_cnt_o  (line_cnt_o),
   .upd_valid   (upd_valid)
);

// File: tb/field_line_qualifier_tb.sv
`timescale 1ns/1ps
module field_line_qualifier_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_stb = 1'b0;
   logic       field_stb = 1'b0;
   logic       relaxed_tol = 1'b0;
   logic [1:0] std_o;
   logic       frame_ok;
   logic [9:0] line_cnt_o;
   logic       upd_valid;

   int total = 0;
   int bad   = 0;
   int carry = 0;
   logic [1:0] prev_std = 2'b00;
   logic       prev_ok  = 1'b0;
   logic [9:0] prev_cnt = '0;

   always #2.5 clk = ~clk;

   field_line_qualifier u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_stb    (line_stb),
      .field_stb   (field_stb),
      .relaxed_tol (relaxed_tol),
      .std_o       (std_o),
      .frame_ok    (frame_ok),
      .line_cnt_o  (line_cnt_o),
      .upd_valid   (upd_valid)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Sends one field of 'lines' line strobes, closes it with a field strobe
   // (optionally together with a line strobe) and checks the result.
   task automatic run_field(input int lines, input bit rel, input bit co_end,
                            input int exp_std, input string req);
      int exp_cnt;
      exp_cnt = (lines > 1023) ? 1023 : lines;
      for (int i = 0; i < lines - carry; i++) begin
         @(negedge clk);
         line_stb = 1'b1; field_stb = 1'b0; relaxed_tol = ~rel;
      end
      @(negedge clk);
      // R8: outputs held and no update pulse while the field runs
      check("R8 hold std", int'(std_o), int'(prev_std));
      check("R8 hold cnt", int'(line_cnt_o), int'(prev_cnt));
      check("R8 no pulse", int'(upd_valid), 0);
      line_stb = co_end; field_stb = 1'b1; relaxed_tol = rel;
      @(posedge clk); #1;
      check({req, " std"}, int'(std_o), exp_std);
      check({req, " frame_ok"}, int'(frame_ok), (exp_std != 0) ? 1 : 0);
      check({"R7/R6 count ", req}, int'(line_cnt_o), exp_cnt);
      check("R8 pulse", int'(upd_valid), 1);
      @(negedge clk);
      line_stb = 1'b0; field_stb = 1'b0; relaxed_tol = ~rel;
      @(posedge clk); #1;
      check("R8 pulse ends", int'(upd_valid), 0);
      check("R8 value kept", int'(line_cnt_o), exp_cnt);
      prev_std = std_o; prev_ok = frame_ok; prev_cnt = line_cnt_o;
      carry = co_end ? 1 : 0;
   endtask

   task automatic test_reset();
      #1;
      check("R9 std", int'(std_o), 0);
      check("R9 frame_ok", int'(frame_ok), 0);
      check("R9 count", int'(line_cnt_o), 0);
      check("R9 valid", int'(upd_valid), 0);
   endtask

   task automatic test_tight();
      run_field(310, 1'b0, 1'b0, 1, "R1 low edge");
      run_field(315, 1'b0, 1'b0, 1, "R1 high edge");
      run_field(309, 1'b0, 1'b0, 0, "R5 tight below 50");
      run_field(316, 1'b0, 1'b0, 0, "R5 tight above 50");
      run_field(260, 1'b0, 1'b0, 2, "R3 low edge");
      run_field(265, 1'b0, 1'b0, 2, "R3 high edge");
      run_field(266, 1'b0, 1'b0, 0, "R5 tight above 60");
      run_field(300, 1'b0, 1'b0, 0, "R5 loose-only count with tight");
   endtask

   task automatic test_loose();
      run_field(290, 1'b1, 1'b0, 1, "R2 low edge");
      run_field(325, 1'b1, 1'b0, 1, "R2 high edge");
      run_field(289, 1'b1, 1'b0, 0, "R5 loose below 50");
      run_field(326, 1'b1, 1'b0, 0, "R5 loose above 50");
      run_field(250, 1'b1, 1'b0, 2, "R4 low edge");
      run_field(275, 1'b1, 1'b0, 2, "R4 high edge");
      run_field(249, 1'b1, 1'b0, 0, "R5 loose below 60");
      run_field(276, 1'b1, 1'b0, 0, "R5 loose above 60");
   endtask

   task automatic test_coincide();
      // R7: shared strobe closes a 300-line field and opens the next
      run_field(300, 1'b1, 1'b1, 1, "R7 closing field");
      run_field(262, 1'b0, 1'b0, 2, "R7 field with carried line");
      run_field(0, 1'b0, 1'b0, 0, "R7 empty field");
   endtask

   task automatic test_saturate();
      run_field(1100, 1'b1, 1'b0, 0, "R6 saturated");
      run_field(1023, 1'b1, 1'b0, 0, "R6 at limit");
      run_field(312, 1'b0, 1'b0, 1, "R6 recovery");
   endtask

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      test_reset();
      @(negedge clk); rst_n = 1'b1;
      test_tight();
      test_loose();
      test_coincide();
      test_saturate();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule